// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flags

This block holds the status word of one scatter-gather DMA channel. The channel datapath sends it one-cycle event pulses: a descriptor finished, a descriptor carried a stop marker, a descriptor had a bad magic value, a descriptor length did not fit the stream width, source and destination addresses were misaligned, or the engine went idle after being told to halt. It also sends one-hot error codes for descriptor-level and read-level faults. Each event becomes a sticky flag. Most events are gated by an interrupt-enable bit from the channel control register.

Software reads the 32-bit word over a simple register bus, with read data registered one cycle after the read strobe. It clears flags by writing ones, qualified by byte enables. When the control register's run bit goes from 0 to 1, every sticky flag is wiped so that a new run starts clean. The interrupt request stays high while any sticky flag is set.

Top module: `dma_chan_status`

## Requirements
- R1: After synchronous active-low reset, all flags are zero, `irq` is low and `bus_rdata` is zero.
- R2: Bit 0 of the word reports the live `busy` input. Writes to bit 0 have no effect on it.
- R3: Each gated event sets its flag when its enable is 1. Stop sets bit 1, done sets bit 2, bad magic sets bit 4, invalid length sets bit 5 and idle-after-halt sets bit 6.
- R4: A gated event whose enable is 0 leaves its flag unchanged.
- R5: The alignment-mismatch event sets bit 3 with no enable.
- R6: Bits 23:19 OR in `desc_err`. Input bit k maps to word bit 19+k: 0 unsupported request, 1 completer abort, 2 parity, 3 poisoned header, 4 unexpected completion.
- R7: Bits 10:9 OR in `rd_err`, with bit 0 a decode error at word bit 9 and bit 1 a slave error at word bit 10. Bits 13:11 read as zero.
- R8: Bits 31:24, 18:14 and 8:7 always read as zero.
- R9: A write with byte lane n enabled clears every flag in bits 8n+7:8n whose write-data bit is 1. Zero data bits, and lanes that are not enabled, change nothing.
- R10: When a set event and a clearing write hit the same flag in one cycle, the flag is set afterwards.
- R11: The cycle after `run` goes from 0 to 1, all flags are zero, even if events arrived in that cycle. While `run` stays high, flags set normally.
- R12: `irq` is high exactly when any flag in bits 23:1 is set.
- R13: `bus_rdata` loads the status word on the clock edge where `bus_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Run bit from the control register |
| ie_stop | input | 1 | Enable for the stop-marker flag |
| ie_done | input | 1 | Enable for the descriptor-done flag |
| ie_magic | input | 1 | Enable for the bad-magic flag |
| ie_len | input | 1 | Enable for the invalid-length flag |
| ie_idle | input | 1 | Enable for the idle-after-halt flag |
| evt_stop | input | 1 | Descriptor with stop marker finished |
| evt_done | input | 1 | Descriptor with completion marker finished |
| evt_magic | input | 1 | Descriptor with bad magic seen |
| evt_len | input | 1 | Length not a multiple of stream width |
| evt_align | input | 1 | Source and destination misaligned |
| evt_idle | input | 1 | Engine went idle after run was cleared |
| desc_err | input | 5 | One-hot descriptor error code |
| rd_err | input | 2 | One-hot read error code |
| busy | input | 1 | Engine is active |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data (ones clear flags) |
| bus_be | input | 4 | Write byte enables |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Gated events are first sent with all enables high and then with all enables low. This separates flags that set from flags that are gated, and shows that the alignment flag ignores enables. Error codes arrive as different one-hot values in turn, which shows accumulation by OR and the bit positions. A write with a single byte lane enabled shows that clears follow lane boundaries. Two collision patterns are also tried: a set arriving together with a clear, and a set arriving together with a run rising edge. They confirm the priority order, and a held-high run confirms that the wipe happens only on the edge.

// File: rtl/dma_stat_pkg.sv
// Shared constants for the DMA channel status word.
// Assumes a 32-bit register bus with byte enables.
package dma_stat_pkg;
    localparam int WORD_W    = 32;
    localparam int BE_W      = WORD_W / 8;
    localparam int POS_BUSY  = 0;
    localparam int FLAG_LSB  = 1;   // stop, done, align, magic, len, idle
    localparam int FLAG_W    = 6;
    localparam int RDE_LSB   = 9;
    localparam int RDE_W     = 2;
    localparam int DESC_LSB  = 19;
    localparam int DESC_W    = 5;
    localparam int STICKY_HI = DESC_LSB + DESC_W - 1;
endpackage

// File: rtl/dma_stat_run_edge.sv
// Detects the 0-to-1 transition of the run bit.
// Assumes run is synchronous to clk.
module dma_stat_run_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic run_rise
);
    logic run_q;

    // Remember the run level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    assign run_rise = run & ~run_q;
endmodule

// File: rtl/dma_stat_w1c_field.sv
// A field of sticky write-one-to-clear bits placed at LSB in the word.
// Priority for each bit: wipe, then set, then a clear by write, then hold.
// Assumes set pulses are one cycle wide and synchronous to clk.
module dma_stat_w1c_field
    import dma_stat_pkg::*;
#(
    parameter int W   = 1,
    parameter int LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic [W-1:0]      set,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [W-1:0]      q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int POS  = LSB + i;
        localparam int LANE = POS / 8;
        logic clr;

        // Clear request when this bit's byte lane is written with a 1.
        assign clr = wr_en & wr_be[LANE] & wr_data[POS];

        // Update one sticky bit in priority order.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (wipe)   q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr)    q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_stat_rdmux.sv
// Builds the status word from its fields and registers it on a read.
// Reserved bits are driven to zero.
module dma_stat_rdmux
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic [FLAG_W-1:0] flags,
    input  logic [RDE_W-1:0]  rde,
    input  logic [DESC_W-1:0] dse,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] rdata
);
    // Place each field at its bit position, all other bits zero.
    always_comb begin
        word = '0;
        word[POS_BUSY] = busy;
        word[FLAG_LSB +: FLAG_W] = flags;
        word[RDE_LSB  +: RDE_W]  = rde;
        word[DESC_LSB +: DESC_W] = dse;
    end

    // Capture the word on a read strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= word;
    end
endmodule

// File: rtl/dma_chan_status.sv
// Status and interrupt flag register of one DMA channel.
// Gates engine events with their enables, keeps sticky flags,
// wipes them when run rises and raises irq while any flag is set.
module dma_chan_status
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ie_stop,
    input  logic              ie_done,
    input  logic              ie_magic,
    input  logic              ie_len,
    input  logic              ie_idle,
    input  logic              evt_stop,
    input  logic              evt_done,
    input  logic              evt_magic,
    input  logic              evt_len,
    input  logic              evt_align,
    input  logic              evt_idle,
    input  logic [DESC_W-1:0] desc_err,
    input  logic [RDE_W-1:0]  rd_err,
    input  logic              busy,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    logic              run_rise;
    logic [FLAG_W-1:0] flag_set;
    logic [FLAG_W-1:0] flag_q;
    logic [RDE_W-1:0]  rde_q;
    logic [DESC_W-1:0] dse_q;
    logic [WORD_W-1:0] stat_word;

    dma_stat_run_edge u_edge (
        .clk(clk), .rst_n(rst_n), .run(run), .run_rise(run_rise)
    );

    // Gate engine events by their enables; alignment has no enable.
    always_comb begin
        flag_set = {evt_idle & ie_idle, evt_len & ie_len, evt_magic & ie_magic,
                    evt_align, evt_done & ie_done, evt_stop & ie_stop};
    end

    dma_stat_w1c_field #(.W(FLAG_W), .LSB(FLAG_LSB)) u_flags (
        .clk(clk), .rst_n(rst_n), .wipe(run_rise), .set(flag_set),
        .wr_en(bus_wr), .wr_data(bus_wdata), .wr_be(bus_be), .q(flag_q)
    );

    dma_stat_w1c_field #(.W(RDE_W), .LSB(RDE_LSB)) u_rde (
        .clk(clk), .rst_n(rst_n), .wipe(run_rise), .set(rd_err),
        .wr_en(bus_wr), .wr_data(bus_wdata), .wr_be(bus_be), .q(rde_q)
    );

    dma_stat_w1c_field #(.W(DESC_W), .LSB(DESC_LSB)) u_dse (
        .clk(clk), .rst_n(rst_n), .wipe(run_rise), .set(desc_err),
        .wr_en(bus_wr), .wr_data(bus_wdata), .wr_be(bus_be), .q(dse_q)
    );

    dma_stat_rdmux u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .busy(busy),
        .flags(flag_q), .rde(rde_q), .dse(dse_q),
        .word(stat_word), .rdata(bus_rdata)
    );

    // Request an interrupt while any sticky flag is set.
    assign irq = |{flag_q, rde_q, dse_q};
endmodule

// File: rtl/dma_chan_status_chk.sv
// Checker for dma_chan_status, attached by bind below.
module dma_chan_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        evt_done,
    input logic        ie_done,
    input logic        busy,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic [31:0] stat_word,
    input logic [31:0] bus_rdata,
    input logic        irq
);
    // R11
    run_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |=> stat_word[23:1] == '0);
    // R3
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && ie_done && !$rose(run)) |=> stat_word[2]);
    // R4
    done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt_done && ie_done) && !stat_word[2]) |=> !stat_word[2]);
    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be[0] && bus_wdata[2] && !(evt_done && ie_done)) |=> !stat_word[2]);
    // R12
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_word[23:1] != '0));
    // R2
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rdata[0] == $past(busy));
    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .evt_done(evt_done), .ie_done(ie_done),
    .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .stat_word(stat_word), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/dma_chan_status_test.sv
`timescale 1ns/1ps
module dma_chan_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 0, ie_stop = 0, ie_done = 0, ie_magic = 0, ie_len = 0, ie_idle = 0;
    logic evt_stop = 0, evt_done = 0, evt_magic = 0, evt_len = 0, evt_align = 0, evt_idle = 0;
    logic [4:0] desc_err = '0;
    logic [1:0] rd_err = '0;
    logic busy = 0, bus_rd = 0, bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_rdata;
    logic irq;
    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    dma_chan_status uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(output logic [31:0] v);
        @(negedge clk); bus_rd = 1;
        @(negedge clk); bus_rd = 0; v = bus_rdata;
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk); bus_wr = 1; bus_wdata = d; bus_be = be;
        @(negedge clk); bus_wr = 0; bus_wdata = '0; bus_be = '0;
    endtask

    task automatic all_evt(input logic v);
        evt_stop = v; evt_done = v; evt_magic = v; evt_len = v; evt_idle = v;
    endtask

    task automatic all_ie(input logic v);
        ie_stop = v; ie_done = v; ie_magic = v; ie_len = v; ie_idle = v;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 rdata at reset", bus_rdata, 32'h0);
        check("R1 irq at reset", {31'b0, irq}, 32'h0);
        rd(v); check("R1 word after reset", v, 32'h0);
    endtask

    task automatic t_busy;
        logic [31:0] v;
        busy = 1; rd(v); check("R2 busy reads 1", v, 32'h1);
        wr(32'h1, 4'hF); rd(v); check("R2 write to busy ignored", v, 32'h1);
        busy = 0; rd(v); check("R2 idle reads 0", v, 32'h0);
    endtask

    task automatic t_enabled;
        logic [31:0] v;
        all_ie(1); @(negedge clk); all_evt(1);
        @(negedge clk); all_evt(0);
        rd(v); check("R3 enabled events set bits 1,2,4,5,6", v, 32'h76);
        check("R12 irq with flags", {31'b0, irq}, 32'h1);
        wr(32'h7E, 4'h2); rd(v); check("R9 other lane write no effect", v, 32'h76);
        wr(32'h0, 4'h1); rd(v); check("R9 zero data no effect", v, 32'h76);
        wr(32'h7E, 4'h1); rd(v); check("R9 clear lane 0", v, 32'h0);
        check("R12 irq low when clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        all_ie(0); @(negedge clk); all_evt(1);
        @(negedge clk); all_evt(0);
        rd(v); check("R4 disabled events ignored", v, 32'h0);
        check("R4 irq stays low", {31'b0, irq}, 32'h0);
        @(negedge clk); evt_align = 1;
        @(negedge clk); evt_align = 0;
        rd(v); check("R5 align sets bit 3", v, 32'h8);
        wr(32'h8, 4'h1);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        @(negedge clk); desc_err = 5'b00001; rd_err = 2'b10;
        @(negedge clk); desc_err = 5'b10000; rd_err = 2'b01;
        @(negedge clk); desc_err = '0; rd_err = '0;
        rd(v);
        check("R6 desc error OR", v & 32'h00F8_0000, 32'h0088_0000);
        check("R7 read error OR", v & 32'h0000_3E00, 32'h0000_0600);
        check("R8 reserved bits zero", v, 32'h0088_0600);
        wr(32'hFFFF_FFFF, 4'b0100); rd(v);
        check("R9 lane 2 clears desc field only", v, 32'h0000_0600);
        wr(32'h0000_0600, 4'b0010); rd(v);
        check("R9 lane 1 clears read field", v, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        ie_done = 1;
        @(negedge clk); evt_done = 1; bus_wr = 1; bus_wdata = 32'h4; bus_be = 4'h1;
        @(negedge clk); evt_done = 0; bus_wr = 0; bus_wdata = 0; bus_be = 0;
        rd(v); check("R10 set beats clear", v, 32'h4);
    endtask

    task automatic t_run;
        logic [31:0] v;
        @(negedge clk); evt_align = 1; desc_err = 5'b00100;
        @(negedge clk); evt_align = 0; desc_err = '0;
        @(negedge clk); run = 1; evt_done = 1; rd_err = 2'b01;
        @(negedge clk); evt_done = 0; rd_err = '0;
        rd(v); check("R11 run rise wipes all", v, 32'h0);
        check("R11 irq low after wipe", {31'b0, irq}, 32'h0);
        @(negedge clk); evt_done = 1;
        @(negedge clk); evt_done = 0;
        rd(v); check("R11 run held does not wipe", v, 32'h4);
        run = 0; wr(32'h4, 4'h1);
    endtask

    task automatic t_rdhold;
        logic [31:0] v;
        rd(v);
        busy = 1; @(negedge clk); evt_align = 1;
        @(negedge clk); evt_align = 0;
        repeat (2) @(negedge clk);
        check("R13 rdata holds without read", bus_rdata, v);
        rd(v); check("R13 rdata loads on read", v, 32'h9);
        busy = 0; wr(32'h8, 4'h1);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_busy;
        t_enabled;
        t_disabled;
        t_errors;
        t_collide;
        t_run;
        t_rdhold;
        finish_run;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule